// File: doc/BRIEF.md
# Value-Checked Transaction Commit Unit

This block sits beside one memory partition and decides whether a transaction may commit. A requester streams in the transaction's log, one entry per beat. Each entry is either a read record (an address and the value the transaction saw there) or a write record (an address and the value it wants stored). The unit holds a small word-addressed memory of its own. For a queued transaction it first re-reads every recorded read address and compares the present word with the recorded value. If all of them agree, it stores the write records in log order and reports a commit. If any of them differs, it reports an abort and leaves memory untouched. Either way, the outcome carries the transaction's ID.

Transactions are handled strictly one after another, in the order their last log beat arrived. Checking and writing for one transaction form a single step, so a later transaction is always checked against the results of every earlier commit. The outcome only says that a conflict exists. It does not say which other transaction caused it. A separate write port loads initial memory contents, and a combinational read port returns any word for ordinary loads.

Top module: `txn_commit_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 0 exactly while QD complete transactions are held (queued or awaiting outcome hand-off). It returns to 1 only after an outcome is taken (`out_valid` and `out_ready` both 1).
- R3: A transaction whose every read record (`in_wr`=0) matches the current memory word gets `out_commit`=1, and all of its write records (`in_wr`=1) are stored.
- R4: A transaction with at least one read record that differs from the current memory word gets `out_commit`=0, and no memory word is changed by it.
- R5: A transaction made only of write records always gets `out_commit`=1.
- R6: Each transaction yields exactly one outcome. Outcomes appear in the order of arrival of the transactions' last beats (`in_last`=1), and `out_id` carries the ID given on that last beat.
- R7: Write records are applied in log order, so when one transaction writes the same address twice, the later value remains.
- R8: Read records are compared against memory as it stood before the transaction's own writes, even when a write record to the same address precedes the read record in the log.
- R9: A transaction is checked against memory that already includes every earlier committed transaction. A read record holding a value that an earlier queued transaction overwrote therefore aborts.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_id` and `out_commit` stay unchanged on the next cycle.
- R11: `init_we`=1 writes `init_data` to word `init_addr` at the clock edge. `rd_data` always shows word `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_we | input | 1 | Memory load enable (use while no transaction is in flight) |
| init_addr | input | AW | Memory load word address |
| init_data | input | DW | Memory load value |
| rd_addr | input | AW | Plain read address |
| rd_data | output | DW | Word at `rd_addr` |
| in_valid | input | 1 | Log beat valid |
| in_ready | output | 1 | Log beat accepted when high with `in_valid` |
| in_id | input | IDW | Transaction ID, taken from the last beat |
| in_wr | input | 1 | 1 = write record, 0 = read record |
| in_addr | input | AW | Record word address |
| in_data | input | DW | Observed value (read) or new value (write) |
| in_last | input | 1 | Marks the final record of a transaction (at most LOGD records) |
| out_valid | output | 1 | Outcome available |
| out_ready | input | 1 | Outcome taken when high with `out_valid` |
| out_id | output | IDW | ID of the reported transaction |
| out_commit | output | 1 | 1 = committed, 0 = aborted |

## Verification
The bench builds the unit with a 16-word memory (AW=4), 8-bit data, up to six records per transaction and a two-transaction queue. The small address space makes reads and writes to the same word common, both inside one log and across queued transactions, so the ordering cases of R7, R8 and R9 also arise from random stimulus. The shallow queue, together with a held-off outcome handshake, makes a full queue and a held outcome quick to reach.

// File: rtl/txn_commit_unit.sv
module txn_commit_unit #(
  parameter int AW   = 4,
  parameter int DW   = 16,
  parameter int LOGD = 8,
  parameter int QD   = 2,
  parameter int IDW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_we,
  input  logic [AW-1:0]  init_addr,
  input  logic [DW-1:0]  init_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [IDW-1:0] in_id,
  input  logic           in_wr,
  input  logic [AW-1:0]  in_addr,
  input  logic [DW-1:0]  in_data,
  input  logic           in_last,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [IDW-1:0] out_id,
  output logic           out_commit
);
  localparam int DEPTH = 1 << AW;
  localparam int IW    = (LOGD > 1) ? $clog2(LOGD) : 1;
  localparam int CW    = $clog2(LOGD + 1);
  localparam int SW    = (QD > 1) ? $clog2(QD) : 1;
  localparam int QW    = $clog2(QD + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_WRITE, ST_DONE} st_t;

  logic [DW-1:0]  mem     [DEPTH];
  logic           lg_wr   [QD][LOGD];
  logic [AW-1:0]  lg_addr [QD][LOGD];
  logic [DW-1:0]  lg_data [QD][LOGD];
  logic [CW-1:0]  slot_n  [QD];
  logic [IDW-1:0] slot_id [QD];

  st_t           state;
  logic [IW-1:0] fill, idx;
  logic [SW-1:0] wr_slot, rd_slot;
  logic [QW-1:0] q_cnt;
  logic          ok;

  logic push_beat, push_txn, pop;
  logic st_chk, st_wr, cw_en;
  logic cur_wr, last_ent, mismatch;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_data;

  assign in_ready   = (q_cnt != QW'(QD));
  assign push_beat  = in_valid && in_ready;
  assign push_txn   = push_beat && in_last;
  assign out_valid  = (state == ST_DONE);
  assign out_id     = slot_id[rd_slot];
  assign out_commit = ok;
  assign pop        = out_valid && out_ready;
  assign rd_data    = mem[rd_addr];

  assign st_chk   = (state == ST_CHECK);
  assign st_wr    = (state == ST_WRITE);
  assign cur_wr   = lg_wr[rd_slot][idx];
  assign cur_addr = lg_addr[rd_slot][idx];
  assign cur_data = lg_data[rd_slot][idx];
  assign last_ent = (CW'(idx) + CW'(1)) == slot_n[rd_slot];
  assign mismatch = st_chk && !cur_wr && (mem[cur_addr] != cur_data);
  assign cw_en    = st_wr && cur_wr;

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] p);
    return (p == SW'(QD - 1)) ? '0 : p + SW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_beat) begin
      lg_wr[wr_slot][fill]   <= in_wr;
      lg_addr[wr_slot][fill] <= in_addr;
      lg_data[wr_slot][fill] <= in_data;
      if (in_last) begin
        slot_n[wr_slot]  <= CW'(fill) + CW'(1);
        slot_id[wr_slot] <= in_id;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cw_en)        mem[cur_addr]  <= cur_data;
    else if (init_we) mem[init_addr] <= init_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill    <= '0;
      wr_slot <= '0;
      q_cnt   <= '0;
    end else begin
      if (push_beat) fill <= in_last ? '0 : fill + IW'(1);
      if (push_txn)  wr_slot <= nxt(wr_slot);
      if (push_txn && !pop)      q_cnt <= q_cnt + QW'(1);
      else if (!push_txn && pop) q_cnt <= q_cnt - QW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      rd_slot <= '0;
      ok      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (q_cnt != '0) begin
          state <= ST_CHECK;
          idx   <= '0;
        end
        ST_CHECK: begin
          if (mismatch) begin
            ok    <= 1'b0;
            state <= ST_DONE;
            idx   <= '0;
          end else if (last_ent) begin
            ok    <= 1'b1;
            state <= ST_WRITE;
            idx   <= '0;
          end else idx <= idx + IW'(1);
        end
        ST_WRITE: begin
          if (last_ent) begin
            state <= ST_DONE;
            idx   <= '0;
          end else idx <= idx + IW'(1);
        end
        default: if (out_ready) begin
          state   <= ST_IDLE;
          rd_slot <= nxt(rd_slot);
        end
      endcase
    end
  end
endmodule

module txn_commit_unit_chk #(
  parameter int IDW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [IDW-1:0] out_id,
  input logic           out_commit,
  input logic           cw_en,
  input logic           ok
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));

  // R2
  ready_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(out_valid && out_ready));

  // R4
  commit_only_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_en |-> ok);

  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  // R10
  outcome_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_id) && $stable(out_commit)));
endmodule

bind txn_commit_unit txn_commit_unit_chk #(.IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_id(out_id), .out_commit(out_commit),
  .cw_en(cw_en), .ok(ok)
);

// File: tb/test_txn_commit_unit.sv
module test_txn_commit_unit;
  localparam int CLK_P = 10;
  localparam int AW = 4, DW = 8, LOGD = 6, QD = 2, IDW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic init_we = 0;
  logic [AW-1:0] init_addr = '0, rd_addr = '0, in_addr = '0;
  logic [DW-1:0] init_data = '0, in_data = '0, rd_data;
  logic in_valid = 0, in_ready, in_wr = 0, in_last = 0;
  logic [IDW-1:0] in_id = '0, out_id;
  logic out_valid, out_ready = 0, out_commit;

  txn_commit_unit #(.AW(AW), .DW(DW), .LOGD(LOGD), .QD(QD), .IDW(IDW)) i_txn_commit_unit (
    .clk(clk), .rst_n(rst_n), .init_we(init_we), .init_addr(init_addr), .init_data(init_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_id(in_id), .in_wr(in_wr), .in_addr(in_addr), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id), .out_commit(out_commit));

  always #(CLK_P/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [DW-1:0] bm [DEPTH];
  logic t_wr [LOGD];
  logic [AW-1:0] t_addr [LOGD];
  logic [DW-1:0] t_data [LOGD];
  int t_n;
  logic [IDW-1:0] exp_id [1024];
  bit exp_ok [1024];
  string exp_tag [1024];
  int n_sent = 0, n_recv = 0;
  bit hold = 0, always_rdy = 1;

  task automatic chk(input bit c, input string tag, input int act, input int exp);
    tests++;
    if (!c) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit predict();
    for (int i = 0; i < t_n; i++)
      if (!t_wr[i] && bm[t_addr[i]] != t_data[i]) return 0;
    for (int i = 0; i < t_n; i++)
      if (t_wr[i]) bm[t_addr[i]] = t_data[i];
    return 1;
  endfunction

  task automatic ent(input int i, input bit w, input int a, input int d);
    t_wr[i] = w; t_addr[i] = AW'(a); t_data[i] = DW'(d);
  endtask

  task automatic send_txn(input logic [IDW-1:0] id, input string tag);
    exp_ok[n_sent]  = predict();
    exp_id[n_sent]  = id;
    exp_tag[n_sent] = tag;
    n_sent++;
    for (int i = 0; i < t_n; i++) begin
      @(negedge clk);
      in_valid = 1; in_id = id; in_wr = t_wr[i]; in_addr = t_addr[i];
      in_data = t_data[i]; in_last = (i == t_n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic drain();
    while (n_recv != n_sent) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic init_write(input int a, input int d);
    @(negedge clk);
    init_we = 1; init_addr = AW'(a); init_data = DW'(d);
    @(posedge clk);
    #1 init_we = 0;
    bm[a] = DW'(d);
  endtask

  task automatic mem_chk(input int a, input string tag);
    @(negedge clk);
    rd_addr = AW'(a);
    #1 chk(rd_data === bm[a], tag, rd_data, bm[a]);
  endtask

  // outcome monitor: R6 order and ID, outcome value per directed tag
  initial begin
    forever begin
      @(negedge clk);
      out_ready = hold ? 1'b0 : (always_rdy ? 1'b1 : 1'($urandom_range(0, 1)));
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (n_recv >= n_sent) chk(0, "R6 unexpected outcome", n_recv, n_sent);
        else begin
          chk(out_id == exp_id[n_recv], "R6 outcome id", out_id, exp_id[n_recv]);
          chk(out_commit == exp_ok[n_recv], exp_tag[n_recv], out_commit, exp_ok[n_recv]);
        end
        n_recv++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected %0d outcomes", n_recv, n_sent);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  logic [IDW-1:0] cap_id;
  logic cap_c;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready, "R1 in_ready after reset", in_ready, 1);

    for (int a = 0; a < DEPTH; a++) init_write(a, a * 7 + 3);
    mem_chk(0, "R11 load/read word 0");
    mem_chk(10, "R11 load/read word 10");
    mem_chk(15, "R11 load/read word 15");

    // R3 R7: reads match, double write to word 5
    t_n = 4; ent(0, 0, 2, bm[2]); ent(1, 1, 5, 8'h11); ent(2, 1, 5, 8'h22); ent(3, 0, 3, bm[3]);
    send_txn(4'h1, "R3 R7 commit outcome");
    drain();
    chk(bm[5] == 8'h22, "R7 model", bm[5], 8'h22);
    mem_chk(5, "R7 later write wins");

    // R4: mismatch, write suppressed
    t_n = 2; ent(0, 0, 5, 8'h99); ent(1, 1, 6, 8'hAA);
    send_txn(4'h2, "R4 abort outcome");
    drain();
    mem_chk(6, "R4 word unchanged after abort");

    // R5: write-only
    t_n = 2; ent(0, 1, 7, 8'h33); ent(1, 1, 8, 8'h44);
    send_txn(4'h3, "R5 write-only commit");
    drain();
    mem_chk(7, "R5 word 7 written");
    mem_chk(8, "R5 word 8 written");

    // R8: read after own write compares old value
    t_n = 2; ent(0, 1, 9, 8'h55); ent(1, 0, 9, bm[9]);
    send_txn(4'h4, "R8 old-value read commits");
    t_n = 2; ent(0, 1, 10, 8'h66); ent(1, 0, 10, 8'h66);
    send_txn(4'h5, "R8 own-value read aborts");
    drain();
    mem_chk(9, "R8 word 9 written");
    mem_chk(10, "R8 word 10 unchanged");

    // R9: second transaction read stale value
    begin
      logic [DW-1:0] old11;
      old11 = bm[11];
      t_n = 2; ent(0, 0, 11, old11); ent(1, 1, 11, old11 + 8'd1);
      send_txn(4'h6, "R9 first commits");
      t_n = 2; ent(0, 0, 11, old11); ent(1, 1, 12, 8'h77);
      send_txn(4'h7, "R9 stale read aborts");
      drain();
      mem_chk(11, "R9 word 11");
      mem_chk(12, "R9 word 12 unchanged");
    end

    // R10 hold and R2 full queue
    hold = 1;
    t_n = 1; ent(0, 1, 13, 8'h5A);
    send_txn(4'h8, "R10 held outcome");
    @(negedge clk); #2;
    chk(in_ready, "R2 ready with one held", in_ready, 1);
    while (!out_valid) begin @(negedge clk); #2; end
    cap_id = out_id; cap_c = out_commit;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #2;
      chk(out_valid && out_id == cap_id && out_commit == cap_c, "R10 outcome held",
          {out_valid, out_id, out_commit}, {1'b1, cap_id, cap_c});
    end
    t_n = 1; ent(0, 0, 13, 8'h5A);
    send_txn(4'h9, "R2 queued txn commits");
    @(negedge clk); #2;
    chk(!in_ready, "R2 not ready when full", in_ready, 0);
    hold = 0;
    drain();
    @(negedge clk); #2;
    chk(in_ready, "R2 ready after drain", in_ready, 1);

    // random mix with random outcome backpressure
    always_rdy = 0;
    for (int k = 0; k < 300; k++) begin
      t_n = $urandom_range(1, LOGD);
      for (int i = 0; i < t_n; i++) begin
        int a;
        a = $urandom_range(0, DEPTH - 1);
        if ($urandom_range(0, 4) < 2) ent(i, 1, a, $urandom_range(0, 255));
        else if ($urandom_range(0, 3) != 0) ent(i, 0, a, bm[a]);
        else ent(i, 0, a, $urandom_range(0, 255));
      end
      send_txn(IDW'(k), "R3 R4 R5 random outcome");
    end
    drain();
    always_rdy = 1;
    for (int a = 0; a < DEPTH; a++) mem_chk(a, "R3 R7 final memory");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule